// File: doc/BRIEF.md
# Byte-Wide Stored-Program Processor Core

This block is a small processor that holds its own program and data. It has sixteen 8-bit general registers and a private store of 256 byte cells. Each instruction is 16 bits wide. The top nibble selects the operation and the three nibbles below it name registers, a byte address or an immediate byte. The core fetches the high byte of an instruction from the cell at the program counter and the low byte from the next cell. It then executes the instruction and repeats this sequence until it reaches a halt instruction.

The surrounding logic loads the program into the store through a valid/ready write channel while the core is idle or halted. A write is accepted on a clock edge where both `ld_valid` and `ld_ready` are high. While the core runs, `ld_ready` is low and the channel is stalled. A pulse on `go` starts execution at `start_addr`. After that, the halted flag, the sticky illegal-opcode flag, the program counter and two combinational debug read ports show the results.

Top module: `byte_cpu`

## Requirements
- R1: A synchronous reset returns the core to idle. After reset the program counter is 00, `halted` and `illegal` are low, `ld_ready` is high and every register reads 00. Reset does not clear the store.
- R2: `ld_ready` is high only while the core is idle or halted. A store write happens exactly on edges where `ld_valid` and `ld_ready` are both high. A `ld_valid` presented while the core runs leaves the store unchanged.
- R3: When `go` is seen in idle, the program counter takes `start_addr`. Each instruction then takes three cycles: the high byte is read at PC, the low byte at PC+1, then execute. The PC advances by 2 per instruction with 8-bit wraparound, so FE is followed by 00.
- R4: 1RXY loads register R from cell XY. 2RXY loads register R with the immediate byte XY.
- R5: 3RXY writes register R into cell XY.
- R6: 40RS copies register R (bits 7:4) into register S (bits 3:0).
- R7: 5RST writes the 8-bit two's-complement sum S+T into register R. The carry is discarded.
- R8: 7RST, 8RST and 9RST write S OR T, S AND T and S XOR T into register R.
- R9: AR0X rotates register R right by X mod 8 bit positions.
- R10: BRXY sets the PC to XY when register R equals register 0. Otherwise the PC keeps its advanced value.
- R11: C000 raises `halted`. `halted` stays high, the PC holds and `go` is ignored until reset.
- R12: Opcodes 0, 6, D, E and F change no register and no cell. They set `illegal`, which stays high until reset, and execution continues.
- R13: `dbg_reg_data` and `dbg_mem_data` show, in the same cycle, the register and the cell selected by the debug inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| go | input | 1 | start pulse, honoured only while idle |
| start_addr | input | 8 | first instruction address |
| ld_valid | input | 1 | program-load write request |
| ld_ready | output | 1 | load channel can accept a write |
| ld_addr | input | 8 | cell to write |
| ld_data | input | 8 | byte to write |
| halted | output | 1 | core has executed a halt |
| illegal | output | 1 | sticky unassigned-opcode flag |
| pc_value | output | 8 | current program counter |
| dbg_reg_sel | input | 4 | register to observe |
| dbg_reg_data | output | 8 | selected register contents |
| dbg_mem_addr | input | 8 | cell to observe |
| dbg_mem_data | output | 8 | selected cell contents |

## Verification
Three programs drive the core. The first adds two cells whose sum overflows, so a dropped carry is distinguished from a kept one and the halt PC is confirmed. The second covers every logic operation and a rotation where the bit order matters. It also includes a taken jump that skips two instructions, a jump that is not taken, and unassigned opcodes scattered between valid ones. The third starts at FE to expose PC wraparound. A behavioural model follows the PC, the flags and load readiness on every clock. Load writes sent mid-run and again after halt separate the ignored case from the accepted one.

// File: rtl/byte_cpu_pkg.sv
package byte_cpu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HI,
    ST_LO,
    ST_EX,
    ST_HALT
  } cpu_state_t;

  localparam logic [3:0] OP_LDM = 4'h1;
  localparam logic [3:0] OP_LDI = 4'h2;
  localparam logic [3:0] OP_STR = 4'h3;
  localparam logic [3:0] OP_MOV = 4'h4;
  localparam logic [3:0] OP_ADD = 4'h5;
  localparam logic [3:0] OP_OR  = 4'h7;
  localparam logic [3:0] OP_AND = 4'h8;
  localparam logic [3:0] OP_XOR = 4'h9;
  localparam logic [3:0] OP_ROR = 4'hA;
  localparam logic [3:0] OP_JEQ = 4'hB;
  localparam logic [3:0] OP_HLT = 4'hC;
endpackage

// File: rtl/byte_cpu_regs.sv
module byte_cpu_regs #(
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [$clog2(NREG)-1:0] ra_addr,
  output logic [DW-1:0]           ra_data,
  input  logic [$clog2(NREG)-1:0] rb_addr,
  output logic [DW-1:0]           rb_data,
  input  logic [$clog2(NREG)-1:0] rc_addr,
  output logic [DW-1:0]           rc_data,
  output logic [DW-1:0]           r0_data,
  input  logic [$clog2(NREG)-1:0] dbg_addr,
  output logic [DW-1:0]           dbg_data
);
  logic [DW-1:0] file_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) file_q[i] <= '0;
    end else if (we) begin
      file_q[waddr] <= wdata;
    end
  end

  assign ra_data  = file_q[ra_addr];
  assign rb_data  = file_q[rb_addr];
  assign rc_data  = file_q[rc_addr];
  assign r0_data  = file_q[0];
  assign dbg_data = file_q[dbg_addr];

  // R4: a register write is visible on the next cycle
  p_wr_lands_r4: assert property (@(posedge clk) disable iff (rst)
    we |=> (file_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/byte_cpu_store.sv
module byte_cpu_store #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic [DW-1:0] core_rdata,
  input  logic          load_we,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_wdata,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (core_we) begin
      cells[core_addr] <= core_wdata;
    end else if (load_we) begin
      cells[load_addr] <= load_wdata;
    end
  end

  assign core_rdata = cells[core_addr];
  assign dbg_data   = cells[dbg_addr];

  // R2: load writes and core writes never meet in one cycle
  p_one_writer_r2: assert property (@(posedge clk) disable iff (rst)
    !(core_we && load_we));
endmodule

// File: rtl/byte_cpu_alu.sv
module byte_cpu_alu
  import byte_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [3:0]    amt,
  output logic [DW-1:0] y
);
  localparam int SW = $clog2(DW);

  logic [SW-1:0]   turn;
  logic [2*DW-1:0] twice;

  assign turn  = amt[SW-1:0];
  assign twice = {a, a} >> turn;

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      OP_XOR:  y = a ^ b;
      OP_ROR:  y = twice[DW-1:0];
      default: y = a;
    endcase
  end
endmodule

// File: rtl/byte_cpu.sv
module byte_cpu
  import byte_cpu_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    go,
  input  logic [AW-1:0]           start_addr,
  input  logic                    ld_valid,
  output logic                    ld_ready,
  input  logic [AW-1:0]           ld_addr,
  input  logic [DW-1:0]           ld_data,
  output logic                    halted,
  output logic                    illegal,
  output logic [AW-1:0]           pc_value,
  input  logic [$clog2(NREG)-1:0] dbg_reg_sel,
  output logic [DW-1:0]           dbg_reg_data,
  input  logic [AW-1:0]           dbg_mem_addr,
  output logic [DW-1:0]           dbg_mem_data
);
  localparam int RW = $clog2(NREG);
  localparam int IW = 2 * DW;

  cpu_state_t state;
  logic [AW-1:0] pc;
  logic [IW-1:0] ir;
  logic          ill_q;

  logic [3:0]    f_op;
  logic [RW-1:0] f_r, f_s, f_t;
  logic [DW-1:0] f_xy;

  logic [DW-1:0] rd_r, rd_s, rd_t, rd_0;
  logic          rf_we;
  logic [RW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata;

  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic          load_we;

  logic [DW-1:0] alu_a, alu_y;
  logic          take_jump, bad_op, is_halt;

  assign f_op = ir[IW-1 -: 4];
  assign f_r  = ir[IW-5 -: RW];
  assign f_s  = ir[IW-9 -: RW];
  assign f_t  = ir[RW-1:0];
  assign f_xy = ir[DW-1:0];

  assign ld_ready = (state == ST_IDLE) || (state == ST_HALT);
  assign load_we  = ld_valid && ld_ready;
  assign halted   = (state == ST_HALT);
  assign illegal  = ill_q;
  assign pc_value = pc;
  assign alu_a    = (f_op == OP_ROR) ? rd_r : rd_s;

  byte_cpu_regs #(.DW(DW), .NREG(NREG)) i_regs (
    .clk(clk), .rst(rst),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_addr(f_r), .ra_data(rd_r),
    .rb_addr(f_s), .rb_data(rd_s),
    .rc_addr(f_t), .rc_data(rd_t),
    .r0_data(rd_0),
    .dbg_addr(dbg_reg_sel), .dbg_data(dbg_reg_data)
  );

  byte_cpu_store #(.DW(DW), .AW(AW)) i_store (
    .clk(clk), .rst(rst),
    .core_we(mem_we), .core_addr(mem_addr), .core_wdata(rd_r),
    .core_rdata(mem_rdata),
    .load_we(load_we), .load_addr(ld_addr), .load_wdata(ld_data),
    .dbg_addr(dbg_mem_addr), .dbg_data(dbg_mem_data)
  );

  byte_cpu_alu #(.DW(DW)) i_alu (
    .op(f_op), .a(alu_a), .b(rd_t), .amt(f_t), .y(alu_y)
  );

  // execute-stage decode
  always_comb begin
    rf_we     = 1'b0;
    rf_waddr  = f_r;
    rf_wdata  = alu_y;
    mem_addr  = pc;
    mem_we    = 1'b0;
    take_jump = 1'b0;
    bad_op    = 1'b0;
    is_halt   = 1'b0;
    if (state == ST_EX) begin
      case (f_op)
        OP_LDM: begin
          mem_addr = f_xy;
          rf_we    = 1'b1;
          rf_wdata = mem_rdata;
        end
        OP_LDI: begin
          rf_we    = 1'b1;
          rf_wdata = f_xy;
        end
        OP_STR: begin
          mem_addr = f_xy;
          mem_we   = 1'b1;
        end
        OP_MOV: begin
          rf_we    = 1'b1;
          rf_waddr = f_t;
          rf_wdata = rd_s;
        end
        OP_ADD, OP_OR, OP_AND, OP_XOR, OP_ROR: rf_we = 1'b1;
        OP_JEQ:  take_jump = (rd_r == rd_0);
        OP_HLT:  is_halt = 1'b1;
        default: bad_op = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pc    <= '0;
      ir    <= '0;
      ill_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (go) begin
            pc    <= start_addr;
            state <= ST_HI;
          end
        end
        ST_HI: begin
          ir[IW-1:DW] <= mem_rdata;
          pc          <= pc + AW'(1);
          state       <= ST_LO;
        end
        ST_LO: begin
          ir[DW-1:0] <= mem_rdata;
          pc         <= pc + AW'(1);
          state      <= ST_EX;
        end
        ST_EX: begin
          if (take_jump) pc <= f_xy;
          if (bad_op) ill_q <= 1'b1;
          state <= is_halt ? ST_HALT : ST_HI;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  // R3: each fetch cycle steps the PC by one cell
  p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HI) |=> (pc == $past(pc) + AW'(1)));

  // R11: the halt is permanent until reset
  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R11: the PC is frozen while halted
  p_pc_hold_r11: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc));

  // R12: the illegal flag never drops without reset
  p_ill_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    illegal |=> illegal);

  // R2: the load channel stalls while instructions are in flight
  p_no_load_run_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EX) |-> !ld_ready);
endmodule

// File: tb/test_byte_cpu.sv
`timescale 1ns/1ps
module test_byte_cpu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       go = 1'b0;
  logic [7:0] start_addr = 8'h00;
  logic       ld_valid = 1'b0;
  logic       ld_ready;
  logic [7:0] ld_addr = 8'h00;
  logic [7:0] ld_data = 8'h00;
  logic       halted, illegal;
  logic [7:0] pc_value;
  logic [3:0] dbg_reg_sel = 4'h0;
  logic [7:0] dbg_reg_data;
  logic [7:0] dbg_mem_addr = 8'h00;
  logic [7:0] dbg_mem_data;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  byte_cpu i_byte_cpu (
    .clk(clk), .rst(rst), .go(go), .start_addr(start_addr),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .ld_data(ld_data), .halted(halted), .illegal(illegal),
    .pc_value(pc_value), .dbg_reg_sel(dbg_reg_sel),
    .dbg_reg_data(dbg_reg_data), .dbg_mem_addr(dbg_mem_addr),
    .dbg_mem_data(dbg_mem_data)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // ---------------- behavioural model, advanced per clock ----------------
  logic [7:0]  m_mem [256];
  logic [7:0]  m_reg [16];
  int          m_ph;       // 0 idle, 1 high byte, 2 low byte, 3 execute, 4 halted
  logic [7:0]  m_pc;
  logic [15:0] m_ir;
  bit          m_ill;

  task automatic model_exec();
    int o, r, s, t;
    logic [7:0] xy, v;
    o  = int'(m_ir[15:12]);
    r  = int'(m_ir[11:8]);
    s  = int'(m_ir[7:4]);
    t  = int'(m_ir[3:0]);
    xy = m_ir[7:0];
    m_ph = 1;
    case (o)
      1:  m_reg[r] = m_mem[xy];
      2:  m_reg[r] = xy;
      3:  m_mem[xy] = m_reg[r];
      4:  m_reg[t] = m_reg[s];
      5:  m_reg[r] = 8'((int'(m_reg[s]) + int'(m_reg[t])) % 256);
      7:  m_reg[r] = m_reg[s] | m_reg[t];
      8:  m_reg[r] = m_reg[s] & m_reg[t];
      9:  m_reg[r] = m_reg[s] ^ m_reg[t];
      10: begin
        v = m_reg[r];
        for (int k = 0; k < t % 8; k++) v = {v[0], v[7:1]};
        m_reg[r] = v;
      end
      11: if (m_reg[r] == m_reg[0]) m_pc = xy;
      12: m_ph = 4;
      default: m_ill = 1'b1;
    endcase
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_pc = 8'h00; m_ir = 16'h0000; m_ill = 1'b0;
      for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
    end else begin
      if (ld_valid && (m_ph == 0 || m_ph == 4)) m_mem[ld_addr] = ld_data;
      case (m_ph)
        0: if (go) begin m_pc = start_addr; m_ph = 1; end
        1: begin m_ir[15:8] = m_mem[m_pc]; m_pc = m_pc + 8'd1; m_ph = 2; end
        2: begin m_ir[7:0]  = m_mem[m_pc]; m_pc = m_pc + 8'd1; m_ph = 3; end
        3: model_exec();
        default: ;
      endcase
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 pc vs model", int'(pc_value), int'(m_pc));
      chk("R11 halted vs model", int'(halted), int'(m_ph == 4));
      chk("R12 illegal vs model", int'(illegal), int'(m_ill));
      chk("R2 ld_ready vs model", int'(ld_ready), int'(m_ph == 0 || m_ph == 4));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic ldb(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic ldw(input logic [7:0] a, input logic [15:0] w);
    ldb(a, w[15:8]);
    ldb(a + 8'd1, w[7:0]);
  endtask

  task automatic run(input logic [7:0] sa);
    @(negedge clk);
    start_addr = sa; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_halt();
    for (int i = 0; i < 3000; i++) begin
      if (halted) break;
      @(negedge clk);
    end
  endtask

  task automatic reg_is(input string tag, input int idx, input int exp);
    dbg_reg_sel = 4'(idx);
    #1;
    chk(tag, int'(dbg_reg_data), exp);
  endtask

  task automatic mem_is(input string tag, input int a, input int exp);
    dbg_mem_addr = 8'(a);
    #1;
    chk(tag, int'(dbg_mem_data), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    // ---- reset state (R1)
    do_reset();
    #1;
    chk("R1 pc after reset", int'(pc_value), 0);
    chk("R1 halted after reset", int'(halted), 0);
    chk("R1 illegal after reset", int'(illegal), 0);
    chk("R1 ld_ready after reset", int'(ld_ready), 1);
    reg_is("R1 r5 cleared", 5, 0);
    reg_is("R13 r0 debug read", 0, 0);

    // ---- program 1: overflowing add via memory operands
    ldb(8'h70, 8'h11);
    ldw(8'h00, 16'h156C);
    ldw(8'h02, 16'h166D);
    ldw(8'h04, 16'h5056);
    ldw(8'h06, 16'h306E);
    ldw(8'h08, 16'hC000);
    ldb(8'h6C, 8'h9A);
    ldb(8'h6D, 8'h7F);
    mem_is("R13 cell debug read", 8'h6C, 8'h9A);
    run(8'h00);
    // R2: writes offered mid-run must be dropped
    ld_valid = 1'b1; ld_addr = 8'h70; ld_data = 8'h55;
    repeat (4) @(negedge clk);
    ld_valid = 1'b0;
    wait_halt();
    chk("R11 halted after C000", int'(halted), 1);
    chk("R3 pc at halt", int'(pc_value), 8'h0A);
    mem_is("R7 sum stored with carry dropped", 8'h6E, 8'h19);
    mem_is("R5 store target", 8'h6E, 8'h19);
    reg_is("R4 load from cell", 5, 8'h9A);
    reg_is("R7 sum register", 0, 8'h19);
    mem_is("R2 mid-run write ignored", 8'h70, 8'h11);
    // R11: go ignored, PC frozen while halted
    run(8'h40);
    repeat (5) @(negedge clk);
    chk("R11 still halted", int'(halted), 1);
    chk("R11 pc holds", int'(pc_value), 8'h0A);
    // R2: accepted again once halted
    ldb(8'h71, 8'hAB);
    mem_is("R2 write accepted when halted", 8'h71, 8'hAB);

    // ---- program 2: logic, rotate, jumps, illegal opcodes
    do_reset();
    #1;
    chk("R1 illegal cleared by reset", int'(illegal), 0);
    chk("R1 halted cleared by reset", int'(halted), 0);
    mem_is("R1 store kept over reset", 8'h71, 8'hAB);
    ldw(8'h10, 16'h2135);
    ldw(8'h12, 16'h22F0);
    ldw(8'h14, 16'h7312);
    ldw(8'h16, 16'h8412);
    ldw(8'h18, 16'h9512);
    ldw(8'h1A, 16'hA103);
    ldw(8'h1C, 16'h4016);
    ldw(8'h1E, 16'h6000);
    ldw(8'h20, 16'h2007);
    ldw(8'h22, 16'h2707);
    ldw(8'h24, 16'hB72A);
    ldw(8'h26, 16'h2899);
    ldw(8'h28, 16'hC000);
    ldw(8'h2A, 16'hB828);
    ldw(8'h2C, 16'h3650);
    ldw(8'h2E, 16'h1950);
    ldw(8'h30, 16'h5A35);
    ldw(8'h32, 16'hD0FF);
    ldw(8'h34, 16'hF123);
    ldw(8'h36, 16'h2B35);
    ldw(8'h38, 16'hAB08);
    ldw(8'h3A, 16'h0000);
    ldw(8'h3C, 16'hC000);
    run(8'h10);
    wait_halt();
    chk("R3 pc at halt prog2", int'(pc_value), 8'h3E);
    chk("R12 illegal raised", int'(illegal), 1);
    reg_is("R4 immediate load", 2, 8'hF0);
    reg_is("R8 or", 3, 8'hF5);
    reg_is("R8 and", 4, 8'h30);
    reg_is("R8 xor", 5, 8'hC5);
    reg_is("R9 rotate by 3", 1, 8'hA6);
    reg_is("R6 move", 6, 8'hA6);
    reg_is("R10 taken jump skipped load", 8, 8'h00);
    reg_is("R4 load back stored byte", 9, 8'hA6);
    mem_is("R5 store r6", 8'h50, 8'hA6);
    reg_is("R7 add wraps", 10, 8'hBA);
    reg_is("R9 rotate by 8 is identity", 11, 8'h35);
    reg_is("R12 r0 untouched by bad opcodes", 0, 8'h07);
    reg_is("R12 r1 untouched by bad opcodes", 1, 8'hA6);
    reg_is("R12 unused r15 still clear", 15, 8'h00);
    mem_is("R12 cell FF not written", 8'hFF, 8'h00);

    // ---- program 3: PC wraparound
    do_reset();
    ldb(8'hFF, 8'h00);
    ldw(8'hFE, 16'h2C42);
    ldw(8'h00, 16'hC000);
    run(8'hFE);
    wait_halt();
    chk("R3 pc wraps past FE", int'(pc_value), 8'h02);
    reg_is("R3 instruction at FE ran", 12, 8'h42);
    chk("R12 no illegal in prog3", int'(illegal), 0);

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule